// File: doc/BRIEF.md
# Saturating Signed Multiply-Accumulate Unit

This unit multiplies two signed operands and adds the product into a 64-bit signed accumulator. The accumulator is held as two 32-bit halves, `acc_hi` (bits 63:32) and `acc_lo` (bits 31:0). Two operation widths exist. The long form multiplies the full 32-bit operands. The word form multiplies only the low 16 bits of each operand, each treated as signed. A saturation flag travels with each operation and selects one of two clamping rules, and each width has its own rule. With the flag clear, the full wrapped 64-bit sum is stored.

The unit is a two-stage pipeline with one control state machine. In state `ST_IDLE` no product is pending. The transition `IDLE_TO_COMMIT` is taken when `op_valid` is sampled high: the product and the flags are registered at that edge. In state `ST_COMMIT` the registered product is added, saturated and written into the accumulator at the next edge. From there, `COMMIT_HOLD` keeps the machine in `ST_COMMIT` when another `op_valid` arrives, so one operation per cycle is accepted. `COMMIT_TO_IDLE` returns to idle when none arrives. Software can clear both halves, or overwrite either half, through the same port.

Top module: `sat_mac`

## Requirements
- R1: A long operation (`op_word`=0) with `sat_en`=0 adds the signed 64-bit product of `opnd_a` and `opnd_b` to {acc_hi, acc_lo}, wrapping modulo 2^64.
- R2: A word operation (`op_word`=1) with `sat_en`=0 adds the signed product of `opnd_a[15:0]` and `opnd_b[15:0]` and ignores the upper operand bits.
- R3: A long operation with `sat_en`=1 forms the 64-bit sum. If the sum is negative, `acc_hi` bits 31:16 are forced to ones. Otherwise `acc_hi` is masked to bits 14:0. `acc_lo` receives the low half of the sum unchanged.
- R4: A word operation with `sat_en`=1 whose signed sum is below -2^31 stores `acc_hi`=1 and `acc_lo`=0x80000000. If the sum is above 2^31-1, it stores `acc_hi`=1 and `acc_lo`=0x7FFFFFFF.
- R5: A word operation with `sat_en`=1 whose sum lies in [-2^31, 2^31-1] stores the sum unchanged.
- R6: `op_valid` sampled at edge k updates the accumulator at edge k+1, and `res_valid` is high for exactly the cycle after edge k+1.
- R7: Operations on consecutive cycles are each accumulated in order, and `res_valid` stays high for one cycle per operation.
- R8: `acc_clr` zeroes both halves at the next edge. It takes precedence over writes and over a committing result, and that result's `res_valid` is suppressed.
- R9: `acc_hi_wr` or `acc_lo_wr` loads `wr_data` into that half at the next edge. It overrides a committing result on that half only.
- R10: After reset both halves are zero and `res_valid` is low.
- R11: Without an operation, clear or write, both halves hold their value whatever the operand inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Start an operation this cycle |
| op_word | input | 1 | 1 = 16x16 word form, 0 = 32x32 long form |
| sat_en | input | 1 | Saturation mode for this operation |
| opnd_a | input | 32 | Signed operand A |
| opnd_b | input | 32 | Signed operand B |
| acc_clr | input | 1 | Zero both accumulator halves |
| acc_hi_wr | input | 1 | Load wr_data into the high half |
| acc_lo_wr | input | 1 | Load wr_data into the low half |
| wr_data | input | 32 | Data for software writes |
| acc_hi | output | 32 | Accumulator bits 63:32 |
| acc_lo | output | 32 | Accumulator bits 31:0 |
| res_valid | output | 1 | Accumulator just updated by an operation |

## Verification
The hardest situations to reach are the word-form clamps. They need a 64-bit sum outside the 32-bit signed range, but a single 16x16 product never gets there. The stimulus reaches them in two ways. One is to repeat maximum positive word products until the sum crosses 2^31-1. The other is to preload the accumulator with exactly -2^31 through software writes and then add -1. Clear and write collisions with a committing result are produced by asserting them in the cycle right after `op_valid`.

// File: rtl/sat_mac_pkg.sv
package sat_mac_pkg;
    typedef enum logic [0:0] {
        ST_IDLE   = 1'b0,
        ST_COMMIT = 1'b1
    } mac_state_t;

    typedef struct packed {
        logic word;
        logic sat;
    } mac_ctl_t;
endpackage

// File: rtl/sat_mac_mult.sv
module sat_mac_mult #(
    parameter int DATA_W = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  load,
    input  logic                  word,
    input  logic [DATA_W-1:0]     a,
    input  logic [DATA_W-1:0]     b,
    output logic [2*DATA_W-1:0]   prod_q
);
    localparam int ACC_W  = 2 * DATA_W;
    localparam int WORD_W = DATA_W / 2;

    logic signed [ACC_W-1:0] a_long, b_long, a_word, b_word, prod_d;

    always_comb begin
        a_long = {{DATA_W{a[DATA_W-1]}}, a};
        b_long = {{DATA_W{b[DATA_W-1]}}, b};
        a_word = {{(ACC_W-WORD_W){a[WORD_W-1]}}, a[WORD_W-1:0]};
        b_word = {{(ACC_W-WORD_W){b[WORD_W-1]}}, b[WORD_W-1:0]};
        prod_d = word ? (a_word * b_word) : (a_long * b_long);
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            prod_q <= '0;
        else if (load)
            prod_q <= prod_d;
    end
endmodule

// File: rtl/sat_mac_clamp.sv
module sat_mac_clamp #(
    parameter int DATA_W = 32
) (
    input  logic [2*DATA_W-1:0] acc_in,
    input  logic [2*DATA_W-1:0] prod,
    input  logic                word,
    input  logic                sat,
    output logic [DATA_W-1:0]   hi_out,
    output logic [DATA_W-1:0]   lo_out
);
    localparam int ACC_W  = 2 * DATA_W;
    localparam int WORD_W = DATA_W / 2;
    localparam logic [DATA_W-1:0] HI_SET_MASK  = {{WORD_W{1'b1}}, {WORD_W{1'b0}}};
    localparam logic [DATA_W-1:0] HI_KEEP_MASK = {{(DATA_W-WORD_W+1){1'b0}}, {(WORD_W-1){1'b1}}};
    localparam logic [DATA_W-1:0] LO_MIN       = {1'b1, {(DATA_W-1){1'b0}}};
    localparam logic [DATA_W-1:0] LO_MAX       = {1'b0, {(DATA_W-1){1'b1}}};
    localparam logic [DATA_W-1:0] HI_FLAG      = {{(DATA_W-1){1'b0}}, 1'b1};
    localparam logic signed [ACC_W-1:0] SUM_MAX = {{(DATA_W+1){1'b0}}, {(DATA_W-1){1'b1}}};
    localparam logic signed [ACC_W-1:0] SUM_MIN = {{(DATA_W+1){1'b1}}, {(DATA_W-1){1'b0}}};

    logic signed [ACC_W-1:0] sum;
    logic [DATA_W-1:0]       sum_hi, sum_lo;

    always_comb begin
        sum    = acc_in + prod;
        sum_hi = sum[ACC_W-1:DATA_W];
        sum_lo = sum[DATA_W-1:0];
        hi_out = sum_hi;
        lo_out = sum_lo;
        if (sat) begin
            if (!word) begin
                hi_out = sum[ACC_W-1] ? (sum_hi | HI_SET_MASK) : (sum_hi & HI_KEEP_MASK);
            end else if (sum < SUM_MIN) begin
                hi_out = HI_FLAG;
                lo_out = LO_MIN;
            end else if (sum > SUM_MAX) begin
                hi_out = HI_FLAG;
                lo_out = LO_MAX;
            end
        end
    end
endmodule

// File: rtl/sat_mac.sv
module sat_mac
    import sat_mac_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic              op_word,
    input  logic              sat_en,
    input  logic [DATA_W-1:0] opnd_a,
    input  logic [DATA_W-1:0] opnd_b,
    input  logic              acc_clr,
    input  logic              acc_hi_wr,
    input  logic              acc_lo_wr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] acc_hi,
    output logic [DATA_W-1:0] acc_lo,
    output logic              res_valid
);
    localparam int ACC_W = 2 * DATA_W;

    mac_state_t        state_q, state_nx;
    mac_ctl_t          ctl_q;
    logic [ACC_W-1:0]  prod_q;
    logic [DATA_W-1:0] new_hi, new_lo;
    logic              commit;

    sat_mac_mult #(.DATA_W(DATA_W)) u_mult (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (op_valid),
        .word   (op_word),
        .a      (opnd_a),
        .b      (opnd_b),
        .prod_q (prod_q)
    );

    sat_mac_clamp #(.DATA_W(DATA_W)) u_clamp (
        .acc_in ({acc_hi, acc_lo}),
        .prod   (prod_q),
        .word   (ctl_q.word),
        .sat    (ctl_q.sat),
        .hi_out (new_hi),
        .lo_out (new_lo)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_nx;
    end

    // Transitions: IDLE_TO_COMMIT, COMMIT_HOLD, COMMIT_TO_IDLE
    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_IDLE:   state_nx = op_valid ? ST_COMMIT : ST_IDLE;
            ST_COMMIT: state_nx = op_valid ? ST_COMMIT : ST_IDLE;
        endcase
    end

    assign commit = (state_q == ST_COMMIT);

    // Outputs and accumulator
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q     <= '0;
            acc_hi    <= '0;
            acc_lo    <= '0;
            res_valid <= 1'b0;
        end else begin
            if (op_valid)
                ctl_q <= '{word: op_word, sat: sat_en};
            res_valid <= commit && !acc_clr;
            if (acc_clr) begin
                acc_hi <= '0;
                acc_lo <= '0;
            end else begin
                if (acc_hi_wr)
                    acc_hi <= wr_data;
                else if (commit)
                    acc_hi <= new_hi;
                if (acc_lo_wr)
                    acc_lo <= wr_data;
                else if (commit)
                    acc_lo <= new_lo;
            end
        end
    end
endmodule

// File: rtl/sat_mac_chk.sv
module sat_mac_chk #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              op_valid,
    input logic              op_word,
    input logic              sat_en,
    input logic              acc_clr,
    input logic              acc_hi_wr,
    input logic              acc_lo_wr,
    input logic [DATA_W-1:0] wr_data,
    input logic [DATA_W-1:0] acc_hi,
    input logic [DATA_W-1:0] acc_lo,
    input logic              res_valid
);
    localparam int WORD_W = DATA_W / 2;
    localparam logic [DATA_W-1:0] LO_MIN = {1'b1, {(DATA_W-1){1'b0}}};
    localparam logic [DATA_W-1:0] LO_MAX = {1'b0, {(DATA_W-1){1'b1}}};

    assert_latency_R6: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid ##1 !acc_clr |=> res_valid);

    assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        acc_clr |=> (acc_hi == '0 && acc_lo == '0 && !res_valid));

    assert_hi_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_hi_wr && !acc_clr) |=> acc_hi == $past(wr_data));

    assert_lo_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_lo_wr && !acc_clr) |=> acc_lo == $past(wr_data));

    assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!acc_clr && !acc_hi_wr && !acc_lo_wr) |=>
            (res_valid || ($stable(acc_hi) && $stable(acc_lo))));

    assert_long_sat_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && $past(op_valid && !op_word && sat_en, 2) && !$past(acc_hi_wr)) |->
            ((&acc_hi[DATA_W-1:WORD_W]) || (acc_hi[DATA_W-1:WORD_W-1] == '0)));

    assert_word_sat_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && $past(op_valid && op_word && sat_en, 2)
            && !$past(acc_hi_wr) && !$past(acc_lo_wr)) |->
            ((acc_hi == DATA_W'(1) && (acc_lo == LO_MIN || acc_lo == LO_MAX))
             || (acc_hi == {DATA_W{acc_lo[DATA_W-1]}})));
endmodule

bind sat_mac sat_mac_chk #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .op_valid  (op_valid),
    .op_word   (op_word),
    .sat_en    (sat_en),
    .acc_clr   (acc_clr),
    .acc_hi_wr (acc_hi_wr),
    .acc_lo_wr (acc_lo_wr),
    .wr_data   (wr_data),
    .acc_hi    (acc_hi),
    .acc_lo    (acc_lo),
    .res_valid (res_valid)
);

// File: tb/sat_mac_bench.sv
module sat_mac_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0, op_word = 1'b0, sat_en = 1'b0;
    logic [31:0] opnd_a = '0, opnd_b = '0, wr_data = '0;
    logic        acc_clr = 1'b0, acc_hi_wr = 1'b0, acc_lo_wr = 1'b0;
    logic [31:0] acc_hi, acc_lo;
    logic        res_valid;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    logic [63:0] exp_acc = '0;

    always #4 clk = ~clk;

    sat_mac u_sat_mac (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_word(op_word),
        .sat_en(sat_en), .opnd_a(opnd_a), .opnd_b(opnd_b), .acc_clr(acc_clr),
        .acc_hi_wr(acc_hi_wr), .acc_lo_wr(acc_lo_wr), .wr_data(wr_data),
        .acc_hi(acc_hi), .acc_lo(acc_lo), .res_valid(res_valid)
    );

    function automatic logic [63:0] ref_mac(input logic [63:0] acc, input logic [31:0] a,
                                            input logic [31:0] b, input bit word, input bit sat);
        longint p, s;
        logic [31:0] h;
        if (word) p = longint'(shortint'(a[15:0])) * longint'(shortint'(b[15:0]));
        else      p = longint'(int'(a)) * longint'(int'(b));
        s = longint'(acc) + p;
        if (!sat) return s;
        if (!word) begin
            h = s[63:32];
            h = (s < 0) ? (h | 32'hFFFF0000) : (h & 32'h00007FFF);
            return {h, s[31:0]};
        end
        if (s < -64'sd2147483648) return {32'd1, 32'h80000000};
        if (s > 64'sd2147483647)  return {32'd1, 32'h7FFFFFFF};
        return s;
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic chk_acc(input string req);
        chk(req, {acc_hi, acc_lo}, exp_acc);
    endtask

    task automatic sw_write(input logic [31:0] hi, input logic [31:0] lo);
        acc_hi_wr = 1; wr_data = hi;
        @(negedge clk);
        acc_hi_wr = 0; acc_lo_wr = 1; wr_data = lo;
        @(negedge clk);
        acc_lo_wr = 0;
        exp_acc = {hi, lo};
    endtask

    task automatic do_op(input string req, input bit word, input bit sat,
                         input logic [31:0] a, input logic [31:0] b);
        op_valid = 1; op_word = word; sat_en = sat; opnd_a = a; opnd_b = b;
        @(negedge clk);
        op_valid = 0;
        chk({req, " not yet valid"}, {63'd0, res_valid}, 64'd0);
        opnd_a = ~a; opnd_b = ~b; op_word = ~word; sat_en = ~sat;
        @(negedge clk);
        exp_acc = ref_mac(exp_acc, a, b, word, sat);
        chk({req, " res_valid"}, {63'd0, res_valid}, 64'd1);
        chk_acc(req);
    endtask

    task automatic t_reset;
        chk("R10 acc", {acc_hi, acc_lo}, 64'd0);
        chk("R10 res_valid", {63'd0, res_valid}, 64'd0);
    endtask

    task automatic t_write_clear;
        sw_write(32'h12345678, 32'h9ABCDEF0);
        chk_acc("R9 write");
        acc_clr = 1; acc_hi_wr = 1; wr_data = 32'hFFFF0000;
        @(negedge clk);
        acc_clr = 0; acc_hi_wr = 0;
        exp_acc = '0;
        chk_acc("R8 clear beats write");
    endtask

    task automatic t_long_plain;
        do_op("R1 max*max", 0, 0, 32'h7FFFFFFF, 32'h7FFFFFFF);
        do_op("R1 neg", 0, 0, 32'hFFFFFFFD, 32'd5);
        sw_write(32'hFFFFFFFF, 32'hFFFFFFFF);
        do_op("R1 wrap", 0, 0, 32'd1, 32'd1);
    endtask

    task automatic t_word_plain;
        sw_write(32'h0, 32'h0);
        do_op("R2 upper bits ignored", 1, 0, 32'hABCD8000, 32'h12340002);
        do_op("R2 pos", 1, 0, 32'h55557FFF, 32'hAAAA7FFF);
    endtask

    task automatic t_long_sat;
        sw_write(32'h00120000, 32'h0);
        do_op("R3 positive mask", 0, 1, 32'hFFFFFFFF, 32'd1);
        chk("R3 hi value", {32'd0, acc_hi}, 64'h7FFF);
        sw_write(32'h80001234, 32'd5);
        do_op("R3 negative ones", 0, 1, 32'd1, 32'd1);
        chk("R3 hi neg value", {32'd0, acc_hi}, 64'hFFFF1234);
    endtask

    task automatic t_word_sat;
        sw_write(32'h0, 32'h0);
        do_op("R5 in range 1", 1, 1, 32'h7FFF, 32'h7FFF);
        do_op("R5 in range 2", 1, 1, 32'h7FFF, 32'h7FFF);
        do_op("R4 overflow", 1, 1, 32'h7FFF, 32'h7FFF);
        chk("R4 overflow value", {acc_hi, acc_lo}, 64'h00000001_7FFFFFFF);
        sw_write(32'hFFFFFFFF, 32'h80000000);
        do_op("R4 underflow", 1, 1, 32'hFFFF, 32'h0001);
        chk("R4 underflow value", {acc_hi, acc_lo}, 64'h00000001_80000000);
        sw_write(32'h0, 32'h0);
        do_op("R5 negative in range", 1, 1, 32'h8000, 32'h0001);
        chk("R5 value", {acc_hi, acc_lo}, 64'hFFFFFFFF_FFFF8000);
    endtask

    task automatic t_back_to_back;
        sw_write(32'h0, 32'h10);
        op_word = 0; sat_en = 0;
        op_valid = 1; opnd_a = 32'd3; opnd_b = 32'd4;
        @(negedge clk);
        opnd_a = 32'hFFFFFFFF; opnd_b = 32'd100;
        @(negedge clk);
        exp_acc = ref_mac(exp_acc, 32'd3, 32'd4, 0, 0);
        chk("R7 first valid", {63'd0, res_valid}, 64'd1);
        chk_acc("R7 first");
        op_word = 1; opnd_a = 32'h00020002; opnd_b = 32'h00030003;
        @(negedge clk);
        op_valid = 0;
        exp_acc = ref_mac(exp_acc, 32'hFFFFFFFF, 32'd100, 0, 0);
        chk("R7 second valid", {63'd0, res_valid}, 64'd1);
        chk_acc("R7 second");
        @(negedge clk);
        exp_acc = ref_mac(exp_acc, 32'h00020002, 32'h00030003, 1, 0);
        chk("R7 third valid", {63'd0, res_valid}, 64'd1);
        chk_acc("R7 third");
        @(negedge clk);
        chk("R6 single pulse", {63'd0, res_valid}, 64'd0);
    endtask

    task automatic t_collisions;
        sw_write(32'h0, 32'h5);
        op_valid = 1; op_word = 0; sat_en = 0; opnd_a = 32'd7; opnd_b = 32'd7;
        @(negedge clk);
        op_valid = 0; acc_clr = 1;
        @(negedge clk);
        acc_clr = 0;
        exp_acc = '0;
        chk_acc("R8 clear beats commit");
        chk("R8 res_valid suppressed", {63'd0, res_valid}, 64'd0);
        sw_write(32'h00000002, 32'h0);
        op_valid = 1; opnd_a = 32'hFFFFFFFF; opnd_b = 32'd1;
        @(negedge clk);
        op_valid = 0; acc_lo_wr = 1; wr_data = 32'hCAFEF00D;
        @(negedge clk);
        acc_lo_wr = 0;
        exp_acc = {32'h00000001, 32'hCAFEF00D};
        chk_acc("R9 write overrides low half only");
    endtask

    task automatic t_idle_hold;
        sw_write(32'h01020304, 32'h05060708);
        for (int i = 0; i < 4; i++) begin
            opnd_a = 32'h11111111 * i; opnd_b = 32'hFFFFFFFF; op_word = i[0]; sat_en = i[1];
            @(negedge clk);
            chk_acc("R11 hold");
            chk("R11 no res_valid", {63'd0, res_valid}, 64'd0);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_write_clear();
        t_long_plain();
        t_word_plain();
        t_long_sat();
        t_word_sat();
        t_back_to_back();
        t_collisions();
        t_idle_hold();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule